// File: doc/BRIEF.md
# Dual-Buffer Receive Frame Store with Destination Filter

This block is the receive half of a small Ethernet MAC. Frame bytes arrive as a stream with a valid strobe and markers for the first and last byte. The block checks the destination field of each frame against the station address. It writes the bytes of a frame into one of two byte buffers, and when the frame ends it decides whether that frame counts. A stored frame raises the full flag of its buffer, may raise an interrupt pulse, and may move the block to the other buffer.

Software owns a control word for each buffer. The word holds a full flag and an interrupt-enable flag. Software reads a frame back through a byte read port and then releases the buffer by writing the full flag to 0. While the full flag of the current buffer is set, the block is not ready, and any frame that starts then is lost. With ping-pong mode on, the two buffers alternate, so one frame can be received while software empties the other.

Top module: `rxpp_frame_store`

## Requirements
- R1: After reset, both full flags and both interrupt-enable flags are 0, the current buffer index is 0, rx_ready is 1 and irq_pulse is 0.
- R2: A frame of at least 6 bytes whose bytes 0..5 equal station_mac is stored into the current buffer. Byte 0 is station_mac[47:40] and byte 5 is station_mac[7:0]. Frame byte k lands at buffer offset k, and the full flag of that buffer is set.
- R3: A frame of at least 6 bytes whose first byte has bit 7 set (a group address) is stored whatever station_mac holds.
- R4: A frame whose first byte has bit 7 clear and which differs from station_mac in any of bytes 0..5 is discarded. A mismatch in byte 5 alone is enough. No full flag changes and the index does not move.
- R5: A frame shorter than 6 bytes is discarded, even when it is a group frame.
- R6: A frame of MAX_LEN (default 2020) bytes or more is discarded. A frame of MAX_LEN-1 bytes is stored in full.
- R7: A frame that starts while the current buffer is full is lost. The buffer contents, the flags and the index stay as they were, and no interrupt is raised.
- R8: When a frame is stored, the index toggles if pingpong_en is 1 and stays put if it is 0. Nothing else moves the index.
- R9: When a frame is stored, irq_pulse is high for exactly one cycle, provided the interrupt-enable flag of the receiving buffer is set and irq_global_en is 1. Otherwise irq_pulse stays low.
- R10: A software write sets the full and interrupt-enable flags of the selected buffer to the written values, and writing full=0 frees the buffer. If a store and a software write to the same buffer fall in the same cycle, the full flag ends up set.
- R11: rx_ready is 1 exactly when the full flag of the current buffer is 0.
- R12: When a byte marked first arrives in the middle of a frame, the earlier frame is abandoned and never stored. The new frame is judged on its own.
- R13: rd_data returns the byte at rd_addr of buffer rd_sel one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_first | input | 1 | This byte is the first byte of a frame |
| rx_last | input | 1 | This byte is the last byte of a frame |
| rx_data | input | 8 | Frame byte |
| station_mac | input | 48 | Station address; bits 47:40 are compared with frame byte 0 |
| pingpong_en | input | 1 | Alternate buffers after each stored frame |
| irq_global_en | input | 1 | Global interrupt enable |
| ctl_wr_en | input | 1 | Software write to a buffer control word |
| ctl_wr_sel | input | 1 | Buffer addressed by the write |
| ctl_wr_full | input | 1 | Full flag value to write |
| ctl_wr_ie | input | 1 | Interrupt-enable value to write |
| rd_sel | input | 1 | Buffer to read |
| rd_addr | input | 11 | Byte offset to read |
| rd_data | output | 8 | Read byte, one cycle after the address |
| buf_full | output | 2 | Full flag of each buffer |
| buf_ie | output | 2 | Interrupt-enable flag of each buffer |
| cur_idx | output | 1 | Buffer that receives the next frame |
| rx_ready | output | 1 | Current buffer is free |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The full flags, the index, rx_ready and irq_pulse all change on the clock edge that samples the last byte of a frame. A control write takes effect on the edge that samples it, and read data follows one edge after its address. The bench changes inputs on falling edges. It samples each result at the falling edge just after the edge on which it is due. It checks irq_pulse at that falling edge and again one cycle later, which confirms that the pulse is exactly one cycle long. Data from a dropped or lost frame is caught by reading back bytes whose values differ between the frames involved.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned MAC_BYTES = 6;
  localparam int unsigned MAC_W     = BYTE_W * MAC_BYTES;
  localparam int unsigned NUM_BUFS  = 2;

  typedef struct packed {
    logic full;
    logic ie;
  } bufctl_t;
endpackage

// File: rtl/rxpp_addr_filter.sv
module rxpp_addr_filter
  import rxpp_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              start,
  input  logic [CW-1:0]     pos,
  input  logic [BYTE_W-1:0] data,
  input  logic [MAC_W-1:0]  mac,
  output logic              pass
);
  logic                 match_q, grp_q;
  logic                 match_n, grp_n, eq;
  logic [MAC_BYTES-1:0] lane_hit;

  // one comparator lane per address byte; byte 0 is the most significant
  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_lane
    assign lane_hit[g] = (pos == CW'(g)) &&
                         (data == mac[MAC_W-1-BYTE_W*g -: BYTE_W]);
  end

  always_comb begin
    eq      = (pos < CW'(MAC_BYTES)) ? |lane_hit : 1'b1;
    match_n = (start ? 1'b1 : match_q) & eq;
    grp_n   = start ? data[BYTE_W-1] : grp_q;
    pass    = match_n | grp_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      grp_q   <= 1'b0;
    end else if (step) begin
      match_q <= match_n;
      grp_q   <= grp_n;
    end
  end
endmodule

// File: rtl/rxpp_frame_writer.sv
module rxpp_frame_writer
  import rxpp_pkg::*;
#(
  parameter int unsigned MAX_LEN = 2020,
  parameter int unsigned AW      = 11,
  parameter int unsigned CW      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_first,
  input  logic              rx_last,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [MAC_W-1:0]  station_mac,
  input  logic              cur_idx,
  input  logic              cur_full,
  output logic              wr_en,
  output logic              wr_sel,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              commit,
  output logic              commit_sel
);
  localparam logic [CW-1:0] POS_LONG = CW'(MAX_LEN - 1);
  localparam logic [CW-1:0] POS_SAT  = CW'(MAX_LEN);
  localparam logic [CW-1:0] POS_ADDR = CW'(MAC_BYTES - 1);

  logic          live_q, lost_q, long_q, tgt_q;
  logic [CW-1:0] cnt_q;
  logic          step, lost_n, long_n, tgt_n, pass;
  logic [CW-1:0] pos;

  always_comb begin
    step   = rx_valid & (rx_first | live_q);
    pos    = rx_first ? '0 : cnt_q;
    lost_n = rx_first ? cur_full : lost_q;
    tgt_n  = rx_first ? cur_idx : tgt_q;
    long_n = (rx_first ? 1'b0 : long_q) | (pos >= POS_LONG);
  end

  rxpp_addr_filter #(.CW(CW)) u_filter (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .start (rx_first),
    .pos   (pos),
    .data  (rx_data),
    .mac   (station_mac),
    .pass  (pass)
  );

  // bytes go straight into the target buffer; only the commit makes them count
  always_comb begin
    wr_en      = step & ~lost_n & ~long_n;
    wr_sel     = tgt_n;
    wr_addr    = pos[AW-1:0];
    wr_data    = rx_data;
    commit     = step & rx_last & ~lost_n & ~long_n & (pos >= POS_ADDR) & pass;
    commit_sel = tgt_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      lost_q <= 1'b0;
      long_q <= 1'b0;
      tgt_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (step) begin
      live_q <= ~rx_last;
      lost_q <= lost_n;
      long_q <= long_n;
      tgt_q  <= tgt_n;
      cnt_q  <= (pos < POS_SAT) ? pos + CW'(1) : pos;
    end
  end
endmodule

// File: rtl/rxpp_buf_ram.sv
module rxpp_buf_ram #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxpp_ctrl.sv
module rxpp_ctrl
  import rxpp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                pingpong_en,
  input  logic                irq_global_en,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic                wr_full,
  input  logic                wr_ie,
  input  logic                commit,
  input  logic                commit_sel,
  output logic [NUM_BUFS-1:0] buf_full,
  output logic [NUM_BUFS-1:0] buf_ie,
  output logic                cur_idx,
  output logic                cur_full,
  output logic                rx_ready,
  output logic                irq_pulse
);
  bufctl_t ctl_q [NUM_BUFS];
  bufctl_t ctl_n [NUM_BUFS];
  logic    idx_q, idx_n, ready_q, irq_q;

  always_comb begin
    for (int b = 0; b < NUM_BUFS; b++) ctl_n[b] = ctl_q[b];
    if (wr_en) begin
      ctl_n[wr_sel].full = wr_full;
      ctl_n[wr_sel].ie   = wr_ie;
    end
    // a store outranks a software clear landing in the same cycle
    if (commit) ctl_n[commit_sel].full = 1'b1;
    idx_n = commit ? (commit_sel ^ pingpong_en) : idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BUFS; b++) ctl_q[b] <= '0;
      idx_q   <= 1'b0;
      ready_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      for (int b = 0; b < NUM_BUFS; b++) ctl_q[b] <= ctl_n[b];
      idx_q   <= idx_n;
      ready_q <= ~ctl_n[idx_n].full;
      irq_q   <= commit & ctl_q[commit_sel].ie & irq_global_en;
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BUFS; b++) begin
      buf_full[b] = ctl_q[b].full;
      buf_ie[b]   = ctl_q[b].ie;
    end
    cur_idx   = idx_q;
    cur_full  = ctl_q[idx_q].full;
    rx_ready  = ready_q;
    irq_pulse = irq_q;
  end
endmodule

// File: rtl/rxpp_frame_store.sv
module rxpp_frame_store
  import rxpp_pkg::*;
#(
  parameter int unsigned MAX_LEN = 2020,
  parameter int unsigned AW      = $clog2(MAX_LEN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_valid,
  input  logic                rx_first,
  input  logic                rx_last,
  input  logic [BYTE_W-1:0]   rx_data,
  input  logic [MAC_W-1:0]    station_mac,
  input  logic                pingpong_en,
  input  logic                irq_global_en,
  input  logic                ctl_wr_en,
  input  logic                ctl_wr_sel,
  input  logic                ctl_wr_full,
  input  logic                ctl_wr_ie,
  input  logic                rd_sel,
  input  logic [AW-1:0]       rd_addr,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [NUM_BUFS-1:0] buf_full,
  output logic [NUM_BUFS-1:0] buf_ie,
  output logic                cur_idx,
  output logic                rx_ready,
  output logic                irq_pulse
);
  localparam int unsigned CW = $clog2(MAX_LEN + 1);

  logic              wr_en, wr_sel, commit, commit_sel, cur_full, rd_sel_q;
  logic [AW-1:0]     wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rdata [NUM_BUFS];

  rxpp_frame_writer #(.MAX_LEN(MAX_LEN), .AW(AW), .CW(CW)) u_writer (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .rx_first    (rx_first),
    .rx_last     (rx_last),
    .rx_data     (rx_data),
    .station_mac (station_mac),
    .cur_idx     (cur_idx),
    .cur_full    (cur_full),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .commit      (commit),
    .commit_sel  (commit_sel)
  );

  rxpp_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .pingpong_en   (pingpong_en),
    .irq_global_en (irq_global_en),
    .wr_en         (ctl_wr_en),
    .wr_sel        (ctl_wr_sel),
    .wr_full       (ctl_wr_full),
    .wr_ie         (ctl_wr_ie),
    .commit        (commit),
    .commit_sel    (commit_sel),
    .buf_full      (buf_full),
    .buf_ie        (buf_ie),
    .cur_idx       (cur_idx),
    .cur_full      (cur_full),
    .rx_ready      (rx_ready),
    .irq_pulse     (irq_pulse)
  );

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    rxpp_buf_ram #(.AW(AW), .DW(BYTE_W)) u_ram (
      .clk   (clk),
      .we    (wr_en && (wr_sel == 1'(b))),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (rdata[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_sel_q <= 1'b0;
    else     rd_sel_q <= rd_sel;
  end

  assign rd_data = rdata[rd_sel_q];
endmodule

// File: rtl/rxpp_frame_store_chk.sv
module rxpp_frame_store_chk (
  input logic       clk,
  input logic       rst,
  input logic       pingpong_en,
  input logic       irq_global_en,
  input logic       cur_idx,
  input logic [1:0] buf_full,
  input logic       rx_ready,
  input logic       irq_pulse
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (buf_full == 2'b00 && !cur_idx && rx_ready && !irq_pulse));

  assert_flip_marks_full_R2: assert property (@(posedge clk) disable iff (rst)
    (cur_idx != $past(cur_idx)) |-> buf_full[$past(cur_idx)]);

  assert_flip_needs_pp_R8: assert property (@(posedge clk) disable iff (rst)
    (cur_idx != $past(cur_idx)) |-> $past(pingpong_en));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(irq_global_en));

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);

  assert_ready_tracks_R11: assert property (@(posedge clk) disable iff (rst)
    rx_ready == !buf_full[cur_idx]);
endmodule

bind rxpp_frame_store rxpp_frame_store_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .pingpong_en   (pingpong_en),
  .irq_global_en (irq_global_en),
  .cur_idx       (cur_idx),
  .buf_full      (buf_full),
  .rx_ready      (rx_ready),
  .irq_pulse     (irq_pulse)
);

// File: tb/tb_rxpp_frame_store.sv
`timescale 1ns/1ps
module tb_rxpp_frame_store;
  localparam int MAX_LEN = 2020;
  localparam int AW = 11;
  localparam logic [47:0] MAC = 48'h02_1A_2B_3C_4D_5E;

  // dst codes: 0 exact match, 1 group, 2 byte-5 mismatch, 3 byte-0 mismatch
  typedef struct packed {
    logic [1:0]  dst;
    logic [11:0] len;
    logic [7:0]  seed;
    logic        store;
  } vec_t;

  localparam vec_t VT [9] = '{
    '{2'd0, 12'd8,   8'd11, 1'b1},
    '{2'd1, 12'd64,  8'd22, 1'b1},
    '{2'd2, 12'd60,  8'd33, 1'b0},
    '{2'd0, 12'd5,   8'd44, 1'b0},
    '{2'd0, 12'd6,   8'd55, 1'b1},
    '{2'd2, 12'd6,   8'd66, 1'b0},
    '{2'd1, 12'd5,   8'd77, 1'b0},
    '{2'd1, 12'd200, 8'd88, 1'b1},
    '{2'd3, 12'd30,  8'd99, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rx_first = 0, rx_last = 0;
  logic [7:0] rx_data = '0;
  logic pingpong_en = 1'b1, irq_global_en = 1'b1;
  logic ctl_wr_en = 0, ctl_wr_sel = 0, ctl_wr_full = 0, ctl_wr_ie = 0;
  logic rd_sel = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] buf_full, buf_ie;
  logic cur_idx, rx_ready, irq_pulse;

  int n_chk = 0, n_bad = 0;
  logic irq1, irq2;
  logic [7:0] rb;
  logic exp_idx;

  always #4 clk = ~clk;

  rxpp_frame_store #(.MAX_LEN(MAX_LEN)) dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_first(rx_first),
    .rx_last(rx_last), .rx_data(rx_data), .station_mac(MAC),
    .pingpong_en(pingpong_en), .irq_global_en(irq_global_en),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_sel(ctl_wr_sel), .ctl_wr_full(ctl_wr_full),
    .ctl_wr_ie(ctl_wr_ie), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .buf_full(buf_full), .buf_ie(buf_ie), .cur_idx(cur_idx),
    .rx_ready(rx_ready), .irq_pulse(irq_pulse)
  );

  function automatic logic [7:0] fbyte(input int dst, input int i, input int seed);
    logic [7:0] m;
    m = MAC[47 - 8*(i % 6) -: 8];
    if (i >= 6) return 8'((i * 3 + seed) & 255);
    case (dst)
      0: return m;
      1: return (i == 0) ? 8'h91 : 8'(8'hA0 + i);
      2: return (i == 5) ? (m ^ 8'h01) : m;
      default: return (i == 0) ? 8'h12 : m;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input int dst, input int len, input int seed,
                            input bit clr_last, input bit clr_sel);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_first = (i == 0);
      rx_last  = (i == len - 1);
      rx_data  = fbyte(dst, i, seed);
      if (clr_last && i == len - 1) begin
        ctl_wr_en = 1'b1; ctl_wr_sel = clr_sel; ctl_wr_full = 1'b0; ctl_wr_ie = 1'b1;
      end
    end
    @(negedge clk);
    rx_valid = 0; rx_first = 0; rx_last = 0; ctl_wr_en = 0;
    irq1 = irq_pulse;
    @(negedge clk);
    irq2 = irq_pulse;
  endtask

  task automatic sw_write(input logic sel, input logic full, input logic ie);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_sel = sel; ctl_wr_full = full; ctl_wr_ie = ie;
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  task automatic read_byte(input logic sel, input int addr, output logic [7:0] d);
    @(negedge clk);
    rd_sel = sel; rd_addr = AW'(addr);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 full", 32'(buf_full), 0);
    check("R1 ie", 32'(buf_ie), 0);
    check("R1 idx", 32'(cur_idx), 0);
    check("R1 ready", 32'(rx_ready), 1);
    check("R1 irq", 32'(irq_pulse), 0);

    sw_write(1'b0, 1'b0, 1'b1);
    sw_write(1'b1, 1'b0, 1'b1);
    check("R10 ie set", 32'(buf_ie), 3);

    // vector table: ping-pong on, interrupts enabled
    exp_idx = 1'b0;
    for (int v = 0; v < 9; v++) begin
      string tag;
      int len;
      len = int'(VT[v].len);
      tag = VT[v].store ? ((VT[v].dst == 1) ? "R3" : "R2")
                        : ((len < 6) ? "R5" : "R4");
      send_frame(int'(VT[v].dst), len, int'(VT[v].seed), 1'b0, 1'b0);
      check({tag, " full"}, 32'(buf_full[exp_idx]), 32'(VT[v].store));
      check({tag, " other full"}, 32'(buf_full[~exp_idx]), 0);
      check({tag, " R8 idx"}, 32'(cur_idx), 32'(exp_idx ^ VT[v].store));
      check({tag, " R9 irq"}, 32'(irq1), 32'(VT[v].store));
      check({tag, " R9 irq width"}, 32'(irq2), 0);
      if (VT[v].store) begin
        read_byte(exp_idx, 0, rb);
        check({tag, " R13 byte0"}, 32'(rb), 32'(fbyte(int'(VT[v].dst), 0, int'(VT[v].seed))));
        read_byte(exp_idx, len - 1, rb);
        check({tag, " R13 last byte"}, 32'(rb),
              32'(fbyte(int'(VT[v].dst), len - 1, int'(VT[v].seed))));
        sw_write(exp_idx, 1'b0, 1'b1);
        check({tag, " R10 freed"}, 32'(buf_full), 0);
        exp_idx = ~exp_idx;
      end
    end

    // R9: global enable off suppresses the pulse
    irq_global_en = 1'b0;
    send_frame(0, 10, 1, 1'b0, 1'b0);
    check("R9 gie off irq", 32'(irq1), 0);
    check("R9 gie off stored", 32'(buf_full[0]), 1);
    sw_write(1'b0, 1'b0, 1'b1);
    irq_global_en = 1'b1;
    // R9: buffer enable off suppresses the pulse (index now 1)
    sw_write(1'b1, 1'b0, 1'b0);
    send_frame(0, 10, 2, 1'b0, 1'b0);
    check("R9 ie off irq", 32'(irq1), 0);
    check("R9 ie off stored", 32'(buf_full[1]), 1);
    sw_write(1'b1, 1'b0, 1'b1);
    check("R8 idx back to 0", 32'(cur_idx), 0);

    // R8: ping-pong off keeps the index
    pingpong_en = 1'b0;
    send_frame(0, 12, 5, 1'b0, 1'b0);
    check("R8 pp off idx", 32'(cur_idx), 0);
    check("R8 pp off full", 32'(buf_full), 1);
    check("R11 ready low", 32'(rx_ready), 0);

    // R7: frame into a full buffer is lost
    send_frame(0, 12, 9, 1'b0, 1'b0);
    check("R7 full kept", 32'(buf_full), 1);
    check("R7 idx kept", 32'(cur_idx), 0);
    check("R7 no irq", 32'(irq1), 0);
    read_byte(1'b0, 6, rb);
    check("R7 data kept", 32'(rb), 32'(fbyte(0, 6, 5)));

    // R10 / R11: software frees and sets the flag
    sw_write(1'b0, 1'b0, 1'b1);
    check("R10 cleared", 32'(buf_full), 0);
    check("R11 ready high", 32'(rx_ready), 1);
    sw_write(1'b0, 1'b1, 1'b1);
    check("R10 sw set", 32'(buf_full), 1);
    check("R11 ready after sw set", 32'(rx_ready), 0);
    sw_write(1'b0, 1'b0, 1'b1);

    // R12: abandoned frame followed by a filtered one stores nothing
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_first = (i == 0); rx_last = 1'b0; rx_data = fbyte(0, i, 4);
    end
    send_frame(2, 20, 4, 1'b0, 1'b0);
    check("R12 abort not stored", 32'(buf_full), 0);
    check("R12 idx", 32'(cur_idx), 0);

    // R10: store wins over a same-cycle software clear
    pingpong_en = 1'b1;
    send_frame(0, 8, 6, 1'b1, 1'b0);
    check("R10 collision full", 32'(buf_full), 1);
    check("R10 collision idx", 32'(cur_idx), 1);
    sw_write(1'b0, 1'b0, 1'b1);

    // R6: length limit (index now 1, ping-pong off)
    pingpong_en = 1'b0;
    send_frame(0, MAX_LEN, 7, 1'b0, 1'b0);
    check("R6 oversize dropped", 32'(buf_full), 0);
    check("R6 oversize idx", 32'(cur_idx), 1);
    send_frame(0, MAX_LEN - 1, 3, 1'b0, 1'b0);
    check("R6 max-1 stored", 32'(buf_full), 2);
    read_byte(1'b1, MAX_LEN - 2, rb);
    check("R6 max-1 last byte", 32'(rb), 32'(fbyte(0, MAX_LEN - 2, 3)));

    finish_run();
  end
endmodule